// File: doc/BRIEF.md
# CPU Trace Word Encoder

This block sits between a processor pipeline and a capture buffer. Each clock it picks one event of that cycle and packs it into a single 32-bit trace word. The event may be a halted pipeline, a register-file write, a program-counter load (jump or pipeline flush), a memory access, or, when nothing else happens, a snapshot of the pipeline control flags. Each word carries its own kind in a short prefix below the most significant bit, so a decoder can read a mixed stream without side information.

The top bit of every word is the trigger flag of the cycle it describes. The capture logic can then find the trigger point in the stored history. Fields are truncated to fit: the register value keeps its low 26 bits, the jump keeps the low 28 bits of the word address, and the memory access keeps 27 bits of either data or word address. The word is registered, so it appears one clock after the inputs that produced it.

Top module: `trace_word_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `trace_word` becomes all zeros after that edge.
- R2: `trace_word` changes only at a rising clock edge. It reflects the inputs sampled at that edge, so the latency is one cycle.
- R3: Bit 31 of `trace_word` equals `trig_in` of the cycle the word describes, for every kind of word.
- R4: When `cpu_halted` is high, the word is the flags word whatever the other strobes are: bits [30:28] = 3'b101 and bits [27:0] = `pipe_flags`.
- R5: A register-write word has bit 30 = 0, bits [29:26] = `rf_idx`, and bits [25:0] = `rf_val[25:0]`.
- R6: When the pipeline is not halted, a register write takes precedence over a jump and over a memory operation in the same cycle.
- R7: A jump word has bits [30:28] = 3'b100 and bits [27:0] = `pc_target[29:2]`, the word address with the two byte-offset bits dropped.
- R8: A jump takes precedence over a memory operation in the same cycle when no register write is present.
- R9: A memory write word has bits [30:27] = 4'b1111 and bits [26:0] = `mem_wdata[26:0]`.
- R10: A memory read word has bits [30:27] = 4'b1110 and bits [26:0] = `mem_addr[28:2]`.
- R11: When no strobe is active and the pipeline is not halted, the word is the flags word of R4.
- R12: Bits [30:28] of `trace_word` never take the value 3'b110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_halted | input | 1 | Pipeline is halted this cycle |
| rf_we | input | 1 | Register-file write strobe |
| rf_idx | input | 4 | Index of the register written |
| rf_val | input | 32 | Value written to the register |
| pc_load | input | 1 | Program counter loaded / pipeline cleared |
| pc_target | input | 32 | Byte address of the new program counter |
| mem_op | input | 1 | Memory operation issued this cycle |
| mem_wr | input | 1 | 1 for a write, 0 for a read |
| mem_addr | input | 32 | Byte address of the memory operation |
| mem_wdata | input | 32 | Write data of the memory operation |
| pipe_flags | input | 28 | Pipeline control flags snapshot |
| trig_in | input | 1 | Trigger flag for this cycle |
| trace_word | output | 32 | Registered trace word |

## Verification
A wrong kind selection shows up in the prefix bits one cycle after the offending inputs. For example, a flags prefix can appear where a register-write prefix belongs, or the unused code 3'b110 can appear. A wrong field slice appears in the same word as a shifted or masked payload. The vectors set several strobes at once, so each level of the priority chain is checked against every level below it. Because the only state is the output register, a fault in reset or in latency is visible at the first word after reset or at the first changed input.

// File: rtl/trace_enc_pkg.sv
// Package: shared word width, event kinds and prefix codes of the trace word.
// Assumes a 32-bit trace word with bit 31 reserved for the trigger flag.
package trace_enc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        KIND_FLAGS = 2'd0,
        KIND_REG   = 2'd1,
        KIND_JUMP  = 2'd2,
        KIND_MEM   = 2'd3
    } trace_kind_t;

    // Prefix codes in bits [30:28]; register writes use only bit 30 = 0.
    localparam logic [2:0] PFX_JUMP  = 3'b100;
    localparam logic [2:0] PFX_FLAGS = 3'b101;
    localparam logic [2:0] PFX_MEM   = 3'b111;
endpackage

// File: rtl/trace_enc_arbiter.sv
// Module: picks which event of the current cycle is recorded.
// Order: halted, register write, jump, memory operation, then idle flags.
// Assumes the strobes are valid for exactly the cycle they describe.
module trace_enc_arbiter
    import trace_enc_pkg::*;
(
    input  logic        halted,
    input  logic        reg_we,
    input  logic        jump,
    input  logic        mem,
    output trace_kind_t kind
);
    // Fixed-priority selection of the recorded event kind
    always_comb begin
        if (halted)
            kind = KIND_FLAGS;
        else if (reg_we)
            kind = KIND_REG;
        else if (jump)
            kind = KIND_JUMP;
        else if (mem)
            kind = KIND_MEM;
        else
            kind = KIND_FLAGS;
    end
endmodule

// File: rtl/trace_enc_formatter.sv
// Module: lays out the chosen event as a prefix-tagged 32-bit word.
// Assumes DATA_W >= 27, ADDR_W >= 30 and FLAG_W = 28, so that every
// truncated field fits below its prefix.
module trace_enc_formatter
    import trace_enc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int FLAG_W = 28
) (
    input  trace_kind_t         kind,
    input  logic                trig,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [DATA_W-1:0]   reg_val,
    input  logic [ADDR_W-1:0]   jump_addr,
    input  logic                mem_wr,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_wdata,
    input  logic [FLAG_W-1:0]   flags,
    output logic [WORD_W-1:0]   word
);
    localparam int REGV_W = WORD_W - 2 - IDX_W;   // register value bits kept
    localparam int JMP_W  = WORD_W - 4;           // word-address bits of a jump
    localparam int MEM_W  = WORD_W - 5;           // memory payload bits

    logic [JMP_W-1:0] jump_field;
    logic [MEM_W-1:0] mem_field;
    logic             unused_bits;

    // Word addresses: drop the two byte-offset bits, keep the low bits
    assign jump_field = jump_addr[JMP_W+1:2];
    assign mem_field  = mem_wr ? mem_wdata[MEM_W-1:0] : mem_addr[MEM_W+1:2];

    // Sink for input bits the format discards
    assign unused_bits = &{1'b0, reg_val[DATA_W-1:REGV_W], jump_addr[1:0],
                           jump_addr[ADDR_W-1:JMP_W+2], mem_addr[1:0],
                           mem_addr[ADDR_W-1:MEM_W+2], mem_wdata[DATA_W-1:MEM_W]};

    // Assemble trigger bit, prefix and payload for the selected kind
    always_comb begin
        unique case (kind)
            KIND_REG:  word = {trig, 1'b0, reg_idx, reg_val[REGV_W-1:0]};
            KIND_JUMP: word = {trig, PFX_JUMP, jump_field};
            KIND_MEM:  word = {trig, PFX_MEM, mem_wr, mem_field};
            default:   word = {trig, PFX_FLAGS, flags};
        endcase
    end
endmodule

// File: rtl/trace_word_enc.sv
// Module: top of the trace encoder; selects, formats and registers one
// trace word per clock. Synchronous active-low reset clears the word.
// Assumes all inputs are synchronous to clk.
module trace_word_enc
    import trace_enc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int FLAG_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_halted,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic [DATA_W-1:0] rf_val,
    input  logic              pc_load,
    input  logic [ADDR_W-1:0] pc_target,
    input  logic              mem_op,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [FLAG_W-1:0] pipe_flags,
    input  logic              trig_in,
    output logic [WORD_W-1:0] trace_word
);
    trace_kind_t       sel_kind;
    logic [WORD_W-1:0] next_word;

    trace_enc_arbiter u_arb (
        .halted (cpu_halted),
        .reg_we (rf_we),
        .jump   (pc_load),
        .mem    (mem_op),
        .kind   (sel_kind)
    );

    trace_enc_formatter #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .FLAG_W (FLAG_W)
    ) u_fmt (
        .kind      (sel_kind),
        .trig      (trig_in),
        .reg_idx   (rf_idx),
        .reg_val   (rf_val),
        .jump_addr (pc_target),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .flags     (pipe_flags),
        .word      (next_word)
    );

    // Output register: one cycle of latency, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            trace_word <= '0;
        else
            trace_word <= next_word;
    end
endmodule

// File: rtl/trace_word_enc_chk.sv
// Module: assertion checker bound to trace_word_enc; relates each output
// word to the inputs of the previous cycle.
module trace_word_enc_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int FLAG_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_halted,
    input logic              rf_we,
    input logic [IDX_W-1:0]  rf_idx,
    input logic [DATA_W-1:0] rf_val,
    input logic              pc_load,
    input logic [ADDR_W-1:0] pc_target,
    input logic              mem_op,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [FLAG_W-1:0] pipe_flags,
    input logic              trig_in,
    input logic [31:0]       trace_word
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> trace_word == 32'h0);

    p_trig_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> trace_word[31] == $past(trig_in));

    p_halt_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cpu_halted)) |->
        (trace_word[30:28] == 3'b101 && trace_word[27:0] == $past(pipe_flags)));

    p_reg_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_halted) && $past(rf_we)) |->
        (trace_word[30] == 1'b0 && trace_word[29:26] == $past(rf_idx)
         && trace_word[25:0] == $past(rf_val[25:0])));

    p_jump_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_halted) && !$past(rf_we) && $past(pc_load)) |->
        (trace_word[30:28] == 3'b100 && trace_word[27:0] == $past(pc_target[29:2])));

    p_mem_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_halted) && !$past(rf_we) && !$past(pc_load)
         && $past(mem_op)) |->
        (trace_word[30:28] == 3'b111 && trace_word[27] == $past(mem_wr)));

    p_no_code110_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trace_word[30:28] != 3'b110);
endmodule

bind trace_word_enc trace_word_enc_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_halted (cpu_halted),
    .rf_we      (rf_we),
    .rf_idx     (rf_idx),
    .rf_val     (rf_val),
    .pc_load    (pc_load),
    .pc_target  (pc_target),
    .mem_op     (mem_op),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pipe_flags (pipe_flags),
    .trig_in    (trig_in),
    .trace_word (trace_word)
);

// File: tb/trace_word_enc_tb.sv
// Bench: table of stimulus/expected vectors, then directed reset and latency tests.
module trace_word_enc_tb;
    typedef struct packed {
        logic        halted;
        logic        we;
        logic [3:0]  idx;
        logic [31:0] val;
        logic        jmp;
        logic [31:0] jaddr;
        logic        mem;
        logic        mwr;
        logic [31:0] maddr;
        logic [31:0] mdata;
        logic [27:0] flags;
        logic        trig;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // idle cycle -> flags word
        '{1'b0,1'b0,4'h0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h0,32'h0,28'h0ABCDEF,1'b0,32'h50ABCDEF,"R11"},
        // halted beats every strobe
        '{1'b1,1'b1,4'h3,32'h11,1'b1,32'h40,1'b1,1'b1,32'h80,32'h99,28'h1234567,1'b1,32'hD1234567,"R4 "},
        // register write beats jump and memory
        '{1'b0,1'b1,4'hA,32'hFFC12345,1'b1,32'h40,1'b1,1'b1,32'h80,32'h99,28'h0,1'b0,32'h2BC12345,"R6 "},
        // register write, all-ones payload and top index
        '{1'b0,1'b1,4'hF,32'h03FFFFFF,1'b0,32'h0,1'b0,1'b0,32'h0,32'h0,28'h0,1'b1,32'hBFFFFFFF,"R5 "},
        // jump beats memory
        '{1'b0,1'b0,4'h0,32'h0,1'b1,32'h06801814,1'b1,1'b0,32'h44,32'h55,28'h0,1'b0,32'h41A00605,"R8 "},
        // jump at highest word address
        '{1'b0,1'b0,4'h0,32'h0,1'b1,32'hFFFFFFFC,1'b0,1'b0,32'h0,32'h0,28'h0,1'b1,32'hCFFFFFFF,"R7 "},
        // memory write keeps low 27 data bits
        '{1'b0,1'b0,4'h0,32'h0,1'b0,32'h0,1'b1,1'b1,32'hFFFFFFFF,32'hF9876543,28'h0,1'b0,32'h79876543,"R9 "},
        // memory read keeps word address
        '{1'b0,1'b0,4'h0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h12345678,32'hFFFFFFFF,28'h0,1'b1,32'hF48D159E,"R10"},
        // idle with trigger and all flags set
        '{1'b0,1'b0,4'h0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h0,32'h0,28'hFFFFFFF,1'b1,32'hDFFFFFFF,"R3 "},
        // halted, zero flags
        '{1'b1,1'b0,4'h0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h0,32'h0,28'h0,1'b0,32'h50000000,"R4 "}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_halted = 1'b0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_idx = '0;
    logic [31:0] rf_val = '0;
    logic        pc_load = 1'b0;
    logic [31:0] pc_target = '0;
    logic        mem_op = 1'b0;
    logic        mem_wr = 1'b0;
    logic [31:0] mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic [27:0] pipe_flags = '0;
    logic        trig_in = 1'b0;
    logic [31:0] trace_word;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    trace_word_enc u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted), .rf_we(rf_we),
        .rf_idx(rf_idx), .rf_val(rf_val), .pc_load(pc_load), .pc_target(pc_target),
        .mem_op(mem_op), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pipe_flags(pipe_flags), .trig_in(trig_in), .trace_word(trace_word)
    );

    task automatic apply(input vec_t v);
        cpu_halted = v.halted; rf_we = v.we; rf_idx = v.idx; rf_val = v.val;
        pc_load = v.jmp; pc_target = v.jaddr; mem_op = v.mem; mem_wr = v.mwr;
        mem_addr = v.maddr; mem_wdata = v.mdata; pipe_flags = v.flags; trig_in = v.trig;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        // R1: reset with busy inputs clears the word
        apply(VECS[1]);
        repeat (3) @(negedge clk);
        check("R1 reset", trace_word, 32'h0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample one full cycle later
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            @(negedge clk);
            check(string'(VECS[i].tag), trace_word, VECS[i].exp);
            check("R12 no code 110", {29'h0, trace_word[30:28] == 3'b110}, 32'h0);
        end

        // R2: a new input does not show before the next rising edge
        @(negedge clk);
        apply(VECS[0]);
        @(negedge clk);
        apply(VECS[3]);
        #1;
        check("R2 hold before edge", trace_word, VECS[0].exp);
        @(negedge clk);
        check("R2 one-cycle update", trace_word, VECS[3].exp);

        // R1: reset asserted mid-run clears on the next edge
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", trace_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resume after reset", trace_word, VECS[3].exp);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: an overlong run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule